// File: doc/BRIEF.md
# Edge-triggered external interrupt controller

This block collects 32 external event lines into one interrupt output and one event output. Each line that the build marks as configurable passes through a two-flop synchronizer and then an edge detector. Software chooses which edges count for each line: rising, falling, or both. A detected rising edge sets a bit in the rising-pending register, and a detected falling edge sets a bit in the falling-pending register. Software clears a pending bit by writing a one to it, so it never needs a read-modify-write. Writing a one to a bit of the software-trigger register makes that line pending, which lets software retrigger a line.

Lines that the build marks as direct skip the edge logic altogether. Their synchronized level counts as active for as long as it is high, and they never set a pending bit. The interrupt output is high while any active line has its bit set in the interrupt mask. The event output follows the same rule with the event mask instead.

The host reaches the registers through a plain single-cycle port. A write is taken on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the interrupt mask, event mask, both edge-select registers and both pending registers read 0, and `irq_o` and `evt_o` are low.
- R2: Register offsets are 0x00 interrupt mask, 0x04 event mask, 0x08 rising-select and 0x0C falling-select, and each reads back what was written. Offset 0x1C is read-only and returns the build parameter `CFG_MASK`, where bit n = 1 means line n is configurable.
- R3: On a configurable line with its rising-select bit set, a 0 to 1 input change sets bit n of the rising-pending register (0x14). With its falling-select bit set, a 1 to 0 change sets bit n of the falling-pending register (0x18). With both set, either edge is caught. The pending bit is visible after the third rising clock edge that samples the new input level.
- R4: A configurable line with neither select bit set never becomes pending from its input.
- R5: Writing 1 to a bit of a pending register clears that bit. Writing 0 leaves it unchanged.
- R6: If a new edge and a clear of the same pending bit fall in the same cycle, the bit stays set.
- R7: Writing 1 to bit n of the software-trigger register (0x10) sets bit n of the rising-pending register on that clock edge. This register always reads 0.
- R8: A direct line (`CFG_MASK` bit 0) never sets a pending bit, whether from an edge or from a software trigger. Its synchronized level, two clock edges after the input changes, counts as active.
- R9: `irq_o` is high exactly when some line is active (rising or falling pending, or a high direct level) and its interrupt-mask bit is 1.
- R10: `evt_o` is high exactly when some line is active and its event-mask bit is 1.
- R11: Reads of unmapped offsets (for example 0x02 and 0x20) return 0. Writes to unmapped offsets or to 0x1C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| lines_i | input | 32 | Asynchronous external event lines |
| irq_o | output | 1 | Combined masked interrupt |
| evt_o | output | 1 | Combined event-masked output |

## Verification
Directed patterns separate the edge modes. One isolated rise and fall is applied per line, under rising-only, falling-only, both and neither selection, so that a swapped select or a swapped pending register shows up. A collision case places a write-one-to-clear on the very cycle an edge is detected. A direct line is toggled with every select bit set and a software trigger written, which shows whether it is wrongly routed through the pending logic. A long constrained-random run toggles sparse line sets and interleaves random writes to mapped and unmapped offsets, and a bench reference model checks every read, `irq_o` and `evt_o` against it each cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int REG_AW = 8;
    typedef logic [REG_AW-1:0] reg_addr_t;

    localparam reg_addr_t OFS_IMASK = 8'h00;
    localparam reg_addr_t OFS_EMASK = 8'h04;
    localparam reg_addr_t OFS_RSEL  = 8'h08;
    localparam reg_addr_t OFS_FSEL  = 8'h0C;
    localparam reg_addr_t OFS_SWTRG = 8'h10;
    localparam reg_addr_t OFS_RPEND = 8'h14;
    localparam reg_addr_t OFS_FPEND = 8'h18;
    localparam reg_addr_t OFS_CAPAB = 8'h1C;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/extint_line.sv
module extint_line #(
    parameter bit CONFIGURABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic prev_i,
    input  logic rsel_i,
    input  logic fsel_i,
    input  logic swset_i,
    input  logic rclr_i,
    input  logic fclr_i,
    output logic rpend_o,
    output logic fpend_o,
    output logic active_o
);
    generate
        if (CONFIGURABLE) begin : g_cfg
            logic rp_q;
            logic fp_q;
            logic rise;
            logic fall;

            assign rise = lvl_i & ~prev_i;
            assign fall = ~lvl_i & prev_i;

            // a fresh edge overrides a same-cycle clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rp_q <= 1'b0;
                    fp_q <= 1'b0;
                end else begin
                    rp_q <= (rp_q & ~rclr_i) | (rise & rsel_i) | swset_i;
                    fp_q <= (fp_q & ~fclr_i) | (fall & fsel_i);
                end
            end

            assign rpend_o  = rp_q;
            assign fpend_o  = fp_q;
            assign active_o = rp_q | fp_q;
        end else begin : g_direct
            logic unused_direct;
            assign unused_direct = &{clk, rst_n, prev_i, rsel_i, fsel_i,
                                     swset_i, rclr_i, fclr_i};
            assign rpend_o  = 1'b0;
            assign fpend_o  = 1'b0;
            assign active_o = lvl_i;
        end
    endgenerate
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int                    NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0]  CFG_MASK  = 32'hFFFF_FF0F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic                 irq_o,
    output logic                 evt_o
);
    logic [NUM_LINES-1:0] imr_q;
    logic [NUM_LINES-1:0] emr_q;
    logic [NUM_LINES-1:0] rsel_q;
    logic [NUM_LINES-1:0] fsel_q;
    logic [NUM_LINES-1:0] rpend;
    logic [NUM_LINES-1:0] fpend;
    logic [NUM_LINES-1:0] active;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] prev;
    logic [NUM_LINES-1:0] swset;
    logic [NUM_LINES-1:0] rclr;
    logic [NUM_LINES-1:0] fclr;

    extint_sync #(.W(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (lines_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    assign swset = (bus_we && bus_addr == OFS_SWTRG) ? bus_wdata : '0;
    assign rclr  = (bus_we && bus_addr == OFS_RPEND) ? bus_wdata : '0;
    assign fclr  = (bus_we && bus_addr == OFS_FPEND) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q  <= '0;
            emr_q  <= '0;
            rsel_q <= '0;
            fsel_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_IMASK: imr_q  <= bus_wdata;
                OFS_EMASK: emr_q  <= bus_wdata;
                OFS_RSEL:  rsel_q <= bus_wdata;
                OFS_FSEL:  fsel_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            extint_line #(.CONFIGURABLE(CFG_MASK[i])) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_i    (lvl[i]),
                .prev_i   (prev[i]),
                .rsel_i   (rsel_q[i]),
                .fsel_i   (fsel_q[i]),
                .swset_i  (swset[i]),
                .rclr_i   (rclr[i]),
                .fclr_i   (fclr[i]),
                .rpend_o  (rpend[i]),
                .fpend_o  (fpend[i]),
                .active_o (active[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            OFS_IMASK: bus_rdata = imr_q;
            OFS_EMASK: bus_rdata = emr_q;
            OFS_RSEL:  bus_rdata = rsel_q;
            OFS_FSEL:  bus_rdata = fsel_q;
            OFS_RPEND: bus_rdata = rpend;
            OFS_FPEND: bus_rdata = fpend;
            OFS_CAPAB: bus_rdata = CFG_MASK;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = |(active & imr_q);
    assign evt_o = |(active & emr_q);
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int                   NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0] CFG_MASK  = 32'hFFFF_FF0F
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [REG_AW-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] bus_wdata,
    input logic                 irq_o,
    input logic                 evt_o,
    input logic [NUM_LINES-1:0] imr,
    input logic [NUM_LINES-1:0] emr,
    input logic [NUM_LINES-1:0] rpend,
    input logic [NUM_LINES-1:0] fpend
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (imr == '0 && emr == '0 && rpend == '0 && fpend == '0));

    // R8
    direct_never_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rpend | fpend) & ~CFG_MASK) == '0);

    // R5
    rpend_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rpend) & ~rpend)) |-> $past(bus_we && bus_addr == OFS_RPEND));

    // R5
    fpend_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(fpend) & ~fpend)) |-> $past(bus_we && bus_addr == OFS_FPEND));

    // R7
    swtrg_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == OFS_SWTRG) |->
            ((rpend & $past(bus_wdata) & CFG_MASK) == ($past(bus_wdata) & CFG_MASK)));

    // R9
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (imr != '0));

    // R10
    evt_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (emr != '0));
endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_LINES(NUM_LINES), .CFG_MASK(CFG_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .evt_o     (evt_o),
    .imr       (imr_q),
    .emr       (emr_q),
    .rpend     (rpend),
    .fpend     (fpend)
);

// File: tb/extint_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
    localparam logic [31:0] CFG = 32'hFFFF_FF0F;
    localparam logic [7:0] A_IM = 8'h00, A_EM = 8'h04, A_RS = 8'h08, A_FS = 8'h0C,
                           A_SW = 8'h10, A_RP = 8'h14, A_FP = 8'h18, A_CP = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] lines = '0;
    logic        irq, evt;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    extint_ctrl #(.NUM_LINES(32), .CFG_MASK(CFG)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .lines_i(lines), .irq_o(irq), .evt_o(evt)
    );

    // reference model built from the requirements
    logic [31:0] m_s1, m_s2, m_prev, m_im, m_em, m_rs, m_fs, m_rp, m_fp;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_im <= '0; m_em <= '0; m_rs <= '0; m_fs <= '0; m_rp <= '0; m_fp <= '0;
        end else begin
            m_s1 <= lines; m_s2 <= m_s1; m_prev <= m_s2;
            if (we && addr == A_IM) m_im <= wdata;
            if (we && addr == A_EM) m_em <= wdata;
            if (we && addr == A_RS) m_rs <= wdata;
            if (we && addr == A_FS) m_fs <= wdata;
            m_rp <= ((m_rp & ~((we && addr == A_RP) ? wdata : 32'h0))
                     | (m_s2 & ~m_prev & m_rs)
                     | ((we && addr == A_SW) ? wdata : 32'h0)) & CFG;
            m_fp <= ((m_fp & ~((we && addr == A_FP) ? wdata : 32'h0))
                     | (~m_s2 & m_prev & m_fs)) & CFG;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            A_IM: return m_im;
            A_EM: return m_em;
            A_RS: return m_rs;
            A_FS: return m_fs;
            A_RP: return m_rp;
            A_FP: return m_fp;
            A_CP: return CFG;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_active();
        return m_rp | m_fp | (m_s2 & ~CFG);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED);
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rdchk("R1 imask", A_IM, 0); rdchk("R1 emask", A_EM, 0);
        rdchk("R1 rsel", A_RS, 0);  rdchk("R1 fsel", A_FS, 0);
        rdchk("R1 rpend", A_RP, 0); rdchk("R1 fpend", A_FP, 0);
        chk("R1 irq", {31'h0, irq}, 0); chk("R1 evt", {31'h0, evt}, 0);

        // R2 offsets and read-back
        wr(A_IM, 32'hA5A5_0F0F); rdchk("R2 imask", A_IM, 32'hA5A5_0F0F);
        wr(A_EM, 32'h5A5A_F0F0); rdchk("R2 emask", A_EM, 32'h5A5A_F0F0);
        rdchk("R2 capab", A_CP, CFG);
        wr(A_IM, 0); wr(A_EM, 0);
        wr(A_RS, 32'h0000_0005); rdchk("R2 rsel", A_RS, 32'h5);
        wr(A_FS, 32'h0000_0006); rdchk("R2 fsel", A_FS, 32'h6);

        // R3 rising only on line 0, with latency
        lines[0] = 1'b1; step(2);
        rdchk("R3 latency", A_RP, 0);
        step(1);
        rdchk("R3 rise", A_RP, 32'h1);
        // falling only on line 1
        lines[1] = 1'b1; step(3); lines[1] = 1'b0; step(3);
        rdchk("R3 fall-only rp", A_RP, 32'h1);
        rdchk("R3 fall-only fp", A_FP, 32'h2);
        // both edges on line 2
        lines[2] = 1'b1; step(3);
        rdchk("R3 both rise", A_RP, 32'h5);
        lines[2] = 1'b0; step(3);
        rdchk("R3 both fall", A_FP, 32'h6);

        // R4 line 3 has no select
        lines[3] = 1'b1; step(3); lines[3] = 1'b0; step(3);
        rdchk("R4 rp", A_RP, 32'h5); rdchk("R4 fp", A_FP, 32'h6);

        // R5 write-one-to-clear
        wr(A_RP, 0);     rdchk("R5 zero write", A_RP, 32'h5);
        wr(A_RP, 32'h1); rdchk("R5 clear rp", A_RP, 32'h4);
        wr(A_FP, 32'h2); rdchk("R5 clear fp", A_FP, 32'h4);

        // R6 edge and clear in the same cycle
        wr(A_SW, 32'h100); rdchk("R6 preset", A_RP, 32'h104);
        wr(A_RS, 32'h105);
        lines[8] = 1'b1; step(2);
        wr(A_RP, 32'h100);
        rdchk("R6 edge wins", A_RP, 32'h104);
        wr(A_RP, 32'h100);
        rdchk("R6 later clear", A_RP, 32'h004);

        // R7 software trigger
        wr(A_SW, 32'h0010_0000);
        rdchk("R7 reads zero", A_SW, 0);
        rdchk("R7 sets rp", A_RP, 32'h0010_0004);
        wr(A_RP, 32'hFFFF_FFFF); wr(A_FP, 32'hFFFF_FFFF);
        rdchk("R5 all clear rp", A_RP, 0); rdchk("R5 all clear fp", A_FP, 0);

        // R8 direct line 5
        wr(A_RS, 32'hFFFF_FFFF); wr(A_FS, 32'hFFFF_FFFF);
        wr(A_SW, 32'h20);
        rdchk("R8 sw ignored", A_RP, 0);
        wr(A_IM, 32'h20);
        chk("R8 irq low", {31'h0, irq}, 0);
        lines[5] = 1'b1; step(1);
        chk("R8 irq sync delay", {31'h0, irq}, 0);
        step(1);
        chk("R8 irq level", {31'h0, irq}, 1);
        step(2);
        rdchk("R8 no rp", A_RP, 0); rdchk("R8 no fp", A_FP, 0);
        lines[5] = 1'b0; step(2);
        chk("R8 irq drop", {31'h0, irq}, 0);

        // R9 / R10 masking
        wr(A_IM, 32'h0020_0000); wr(A_SW, 32'h0010_0000);
        chk("R9 masked", {31'h0, irq}, 0);
        wr(A_IM, 32'h0010_0000);
        chk("R9 unmasked", {31'h0, irq}, 1);
        chk("R10 evt masked", {31'h0, evt}, 0);
        wr(A_EM, 32'h0010_0000);
        chk("R10 evt", {31'h0, evt}, 1);
        wr(A_RP, 32'h0010_0000);
        chk("R9 irq cleared", {31'h0, irq}, 0);
        chk("R10 evt cleared", {31'h0, evt}, 0);

        // R11 unmapped offsets
        wr(A_IM, 32'h1234_5678);
        wr(8'h20, 32'hFFFF_FFFF); wr(A_CP, 32'h0); wr(8'h02, 32'hFFFF_FFFF);
        rdchk("R11 read 0x20", 8'h20, 0); rdchk("R11 read 0x02", 8'h02, 0);
        rdchk("R11 imask kept", A_IM, 32'h1234_5678);
        rdchk("R11 capab kept", A_CP, CFG);
        rdchk("R11 rsel kept", A_RS, 32'hFFFF_FFFF);
        rdchk("R11 rpend kept", A_RP, 0);

        // random phase against the model
        for (int it = 0; it < 3000; it++) begin
            we = 1'b0;
            addr = 8'(($urandom % 9) * 4);
            #1;
            chk("R2/R3/R7 random read", rdata, exp_read(addr));
            chk("R9 random irq", {31'h0, irq}, {31'h0, |(exp_active() & m_im)});
            chk("R10 random evt", {31'h0, evt}, {31'h0, |(exp_active() & m_em)});
            lines = lines ^ ($urandom & $urandom & $urandom);
            if ($urandom % 3 == 0) begin
                we = 1'b1;
                addr = 8'(($urandom % 9) * 4);
                wdata = $urandom;
            end
            @(negedge clk);
        end
        we = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule